// File: doc/BRIEF.md
# Software-Managed Translation Table

This block holds a fully associative table of sixteen translation entries. Each entry covers a pair of adjacent virtual pages, an even page and an odd page. It keeps one virtual page tag, one address-space identifier, one global flag, a page-size mask and two physical halves. Each half has a valid flag, a dirty flag, a cache attribute and a page frame number. The table never changes by itself. Software manages it through four commands: probe, write at the index, write at the random slot, and read back.

The host core keeps its translation control registers outside the block and presents their current values on the inputs. These are the virtual tag with identifier, the two physical halves, the page mask and the index. A one-cycle command strobe carries a two-bit opcode. On the next clock edge the block returns the updated register values on its outputs. A probe returns the matching slot, or a miss flag, in the index output. A read unpacks a stored entry back into register form and raises a one-cycle pulse when the identifier it loads differs from the one currently presented. The host uses that pulse to flush any cached translations for the old address space.

Top module: `soft_tlb`

## Requirements
- R1: A write stores entryHiIn[31:13] as the tag and entryHiIn[7:0] as the identifier. A read returns entryHiOut = {tag, 5'b0, identifier}, so bits 12:8 are zero.
- R2: A written entry is global only when bit 0 of both entryLo0In and entryLo1In is 1. A read places the stored global flag in bit 0 of both entryLo0Out and entryLo1Out.
- R3: Each physical half is taken from its EntryLo input with bit 1 as valid, bit 2 as dirty, bits 5:3 as cache attribute and bits 29:6 as frame number. A read rebuilds each output with those fields in the same positions and bits 31:30 zero.
- R4: The page mask presented at a write is stored whole and returned unchanged on pageMaskOut by a read of that entry.
- R5: A probe matches an entry whose tag equals entryHiIn[31:13] and that is either global or has an identifier equal to entryHiIn[7:0]. On a match, indexOut becomes the lowest matching slot number, with all other bits zero.
- R6: On a probe with no match, indexOut becomes indexIn with bit 31 set, so bits 3:0 keep their presented value.
- R7: Write-at-index and read select the slot with indexIn[3:0] alone; higher index bits have no effect.
- R8: Write-at-random selects the slot with randIdx and leaves the slot named by indexIn untouched.
- R9: A read pulses asidChange high for exactly one cycle when the stored identifier differs from entryHiIn[7:0]; otherwise asidChange stays low.
- R10: Opcodes are 0 probe, 1 write-at-index, 2 write-at-random, 3 read, accepted when cmdValid is 1. Outputs change at the accepting edge: outputs that a command does not produce copy their inputs. With cmdValid low all outputs hold.
- R11: Reset (rstN low) clears all outputs and every field of every entry, so a read of any slot afterwards returns zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cmdValid | input | 1 | Command strobe |
| cmdOp | input | 2 | Command opcode |
| entryHiIn | input | 32 | Virtual tag and identifier register value |
| entryLo0In | input | 32 | Even-page physical half register value |
| entryLo1In | input | 32 | Odd-page physical half register value |
| pageMaskIn | input | 32 | Page mask register value |
| indexIn | input | 32 | Index register value |
| randIdx | input | 4 | Slot used by write-at-random |
| indexOut | output | 32 | Updated index value |
| entryHiOut | output | 32 | Returned tag and identifier value |
| entryLo0Out | output | 32 | Returned even-page half |
| entryLo1Out | output | 32 | Returned odd-page half |
| pageMaskOut | output | 32 | Returned page mask |
| asidChange | output | 1 | One-cycle pulse on an identifier change during a read |

## Verification
Every result is registered exactly once, so all outputs of a command, including the asidChange pulse, are valid from the first rising edge after the command is presented. They stay valid until the next edge. The bench drives a command at a falling edge and removes it at the following falling edge, then samples outputs at that same falling edge, half a cycle after they settle. It checks one falling edge later that the asidChange pulse has dropped and that outputs hold while no command is presented.

// File: rtl/soft_tlb_pkg.sv
package soft_tlb_pkg;

  localparam int REG_W   = 32;
  localparam int TAG_LSB = 13;
  localparam int TAG_W   = REG_W - TAG_LSB;
  localparam int ASID_W  = 8;
  localparam int CATTR_W = 3;
  localparam int PFN_LSB = 6;
  localparam int PFN_W   = 24;
  localparam int GAP_W   = TAG_LSB - ASID_W;
  localparam int TOP_W   = REG_W - PFN_LSB - PFN_W;

  typedef enum logic [1:0] {
    OP_PROBE  = 2'd0,
    OP_WR_IDX = 2'd1,
    OP_WR_RND = 2'd2,
    OP_READ   = 2'd3
  } opT;

  typedef struct packed {
    logic               valid;
    logic               dirty;
    logic [CATTR_W-1:0] cattr;
    logic [PFN_W-1:0]   pfn;
  } halfT;

  typedef struct packed {
    logic [TAG_W-1:0]  tag;
    logic [ASID_W-1:0] asid;
    logic              glob;
    logic [REG_W-1:0]  pmask;
    halfT              even;
    halfT              odd;
  } entryT;

  typedef struct packed {
    logic probe;
    logic wrIdx;
    logic wrRnd;
    logic rd;
  } strobeT;

  function automatic halfT unpackLo(input logic [REG_W-1:0] lo);
    halfT h;
    h.valid = lo[1];
    h.dirty = lo[2];
    h.cattr = lo[3 +: CATTR_W];
    h.pfn   = lo[PFN_LSB +: PFN_W];
    return h;
  endfunction

  function automatic logic [REG_W-1:0] packLo(input halfT h, input logic g);
    return {{TOP_W{1'b0}}, h.pfn, h.cattr, h.dirty, h.valid, g};
  endfunction

  function automatic logic [REG_W-1:0] packHi(input entryT e);
    return {e.tag, {GAP_W{1'b0}}, e.asid};
  endfunction

endpackage

// File: rtl/soft_tlb_ctrl.sv
module soft_tlb_ctrl
  import soft_tlb_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  input  logic [1:0]       cmdOp,
  input  logic [IDX_W-1:0] idxSel,
  input  logic [IDX_W-1:0] randIdx,
  output strobeT           stb,
  output logic [IDX_W-1:0] slot
);

  opT op;

  always_comb begin
    op  = opT'(cmdOp);
    stb = '0;
    if (cmdValid) begin
      unique case (op)
        OP_PROBE:  stb.probe = 1'b1;
        OP_WR_IDX: stb.wrIdx = 1'b1;
        OP_WR_RND: stb.wrRnd = 1'b1;
        OP_READ:   stb.rd    = 1'b1;
        default:   stb       = '0;
      endcase
    end
  end

  // write-at-random takes its slot from the random source, all else from index
  always_comb begin
    slot = stb.wrRnd ? randIdx : idxSel;
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(stb)) else $error("more than one command strobe"); // R10

  AST_STROBE_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    !cmdValid |-> (stb == '0)) else $error("strobe without cmdValid"); // R10

endmodule

// File: rtl/soft_tlb_match.sv
module soft_tlb_match
  import soft_tlb_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int IDX_W       = $clog2(NUM_ENTRIES)
) (
  input  logic [TAG_W-1:0]  tagArr  [NUM_ENTRIES],
  input  logic [ASID_W-1:0] asidArr [NUM_ENTRIES],
  input  logic              globArr [NUM_ENTRIES],
  input  logic [TAG_W-1:0]  keyTag,
  input  logic [ASID_W-1:0] keyAsid,
  output logic              anyHit,
  output logic [IDX_W-1:0]  hitIdx
);

  logic [NUM_ENTRIES-1:0] hitVec;

  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_cmp
    assign hitVec[e] = (tagArr[e] == keyTag) &&
                       (globArr[e] || (asidArr[e] == keyAsid));
  end

  // lowest matching slot wins
  always_comb begin
    hitIdx = '0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (hitVec[i]) hitIdx = IDX_W'(i);
    end
  end

  assign anyHit = |hitVec;

endmodule

// File: rtl/soft_tlb_store.sv
module soft_tlb_store
  import soft_tlb_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int IDX_W       = $clog2(NUM_ENTRIES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobeT           stb,
  input  logic [IDX_W-1:0] slot,
  input  logic [REG_W-1:0] entryHiIn,
  input  logic [REG_W-1:0] entryLo0In,
  input  logic [REG_W-1:0] entryLo1In,
  input  logic [REG_W-1:0] pageMaskIn,
  input  logic [REG_W-1:0] indexIn,
  output logic [REG_W-1:0] indexOut,
  output logic [REG_W-1:0] entryHiOut,
  output logic [REG_W-1:0] entryLo0Out,
  output logic [REG_W-1:0] entryLo1Out,
  output logic [REG_W-1:0] pageMaskOut,
  output logic             asidChange
);

  entryT             tbl     [NUM_ENTRIES];
  logic [TAG_W-1:0]  tagArr  [NUM_ENTRIES];
  logic [ASID_W-1:0] asidArr [NUM_ENTRIES];
  logic              globArr [NUM_ENTRIES];

  logic [TAG_W-1:0]  keyTag;
  logic [ASID_W-1:0] keyAsid;
  logic              anyHit;
  logic [IDX_W-1:0]  hitIdx;
  logic              wrEn;
  logic              anyCmd;
  entryT             newEntry;
  entryT             selEntry;

  assign keyTag  = entryHiIn[TAG_LSB +: TAG_W];
  assign keyAsid = entryHiIn[ASID_W-1:0];
  assign wrEn    = stb.wrIdx | stb.wrRnd;
  assign anyCmd  = stb.probe | wrEn | stb.rd;

  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_view
    assign tagArr[e]  = tbl[e].tag;
    assign asidArr[e] = tbl[e].asid;
    assign globArr[e] = tbl[e].glob;
  end

  soft_tlb_match #(
    .NUM_ENTRIES(NUM_ENTRIES),
    .IDX_W      (IDX_W)
  ) u_match (
    .tagArr (tagArr),
    .asidArr(asidArr),
    .globArr(globArr),
    .keyTag (keyTag),
    .keyAsid(keyAsid),
    .anyHit (anyHit),
    .hitIdx (hitIdx)
  );

  always_comb begin
    newEntry.tag   = keyTag;
    newEntry.asid  = keyAsid;
    newEntry.glob  = entryLo0In[0] & entryLo1In[0];
    newEntry.pmask = pageMaskIn;
    newEntry.even  = unpackLo(entryLo0In);
    newEntry.odd   = unpackLo(entryLo1In);
  end

  assign selEntry = tbl[slot];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_ENTRIES; i++) tbl[i] <= '0;
    end else if (wrEn) begin
      for (int i = 0; i < NUM_ENTRIES; i++) begin
        if (slot == IDX_W'(i)) tbl[i] <= newEntry;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      indexOut    <= '0;
      entryHiOut  <= '0;
      entryLo0Out <= '0;
      entryLo1Out <= '0;
      pageMaskOut <= '0;
      asidChange  <= 1'b0;
    end else begin
      asidChange <= 1'b0;
      if (anyCmd) begin
        indexOut    <= indexIn;
        entryHiOut  <= entryHiIn;
        entryLo0Out <= entryLo0In;
        entryLo1Out <= entryLo1In;
        pageMaskOut <= pageMaskIn;
        if (stb.probe) begin
          if (anyHit) indexOut <= REG_W'(hitIdx);
          else        indexOut <= {1'b1, indexIn[REG_W-2:0]};
        end
        if (stb.rd) begin
          entryHiOut  <= packHi(selEntry);
          entryLo0Out <= packLo(selEntry.even, selEntry.glob);
          entryLo1Out <= packLo(selEntry.odd, selEntry.glob);
          pageMaskOut <= selEntry.pmask;
          asidChange  <= (selEntry.asid != keyAsid);
        end
      end
    end
  end

  AST_HI_GAP_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    stb.rd |=> (entryHiOut[TAG_LSB-1:ASID_W] == '0)) else $error("gap bits set"); // R1

  AST_GLOBAL_PAIR: assert property (@(posedge clk) disable iff (!rstN)
    stb.rd |=> (entryLo0Out[0] == entryLo1Out[0])) else $error("global bits differ"); // R2

  AST_LO_TOP_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    stb.rd |=> (entryLo0Out[REG_W-1:PFN_LSB+PFN_W] == '0)) else $error("lo top bits"); // R3

  AST_PROBE_HIT_IDX: assert property (@(posedge clk) disable iff (!rstN)
    (stb.probe && anyHit) |=> (indexOut == REG_W'($past(hitIdx)))) else $error("hit index"); // R5

  AST_PROBE_MISS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (stb.probe && !anyHit) |=> (indexOut[REG_W-1] &&
      indexOut[IDX_W-1:0] == $past(indexIn[IDX_W-1:0]))) else $error("miss flag"); // R6

  AST_ASID_PULSE_SRC: assert property (@(posedge clk) disable iff (!rstN)
    asidChange |-> $past(stb.rd)) else $error("pulse without read"); // R9

  AST_ASID_PULSE_SHORT: assert property (@(posedge clk) disable iff (!rstN)
    (asidChange && !stb.rd) |=> !asidChange) else $error("pulse too long"); // R9

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !anyCmd |=> ($stable(indexOut) && $stable(entryHiOut) && $stable(pageMaskOut)))
    else $error("outputs moved while idle"); // R10

endmodule

// File: rtl/soft_tlb.sv
module soft_tlb
  import soft_tlb_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  localparam int IDX_W      = $clog2(NUM_ENTRIES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  input  logic [1:0]       cmdOp,
  input  logic [31:0]      entryHiIn,
  input  logic [31:0]      entryLo0In,
  input  logic [31:0]      entryLo1In,
  input  logic [31:0]      pageMaskIn,
  input  logic [31:0]      indexIn,
  input  logic [IDX_W-1:0] randIdx,
  output logic [31:0]      indexOut,
  output logic [31:0]      entryHiOut,
  output logic [31:0]      entryLo0Out,
  output logic [31:0]      entryLo1Out,
  output logic [31:0]      pageMaskOut,
  output logic             asidChange
);

  strobeT           stb;
  logic [IDX_W-1:0] slot;

  soft_tlb_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .cmdValid(cmdValid),
    .cmdOp   (cmdOp),
    .idxSel  (indexIn[IDX_W-1:0]),
    .randIdx (randIdx),
    .stb     (stb),
    .slot    (slot)
  );

  soft_tlb_store #(
    .NUM_ENTRIES(NUM_ENTRIES),
    .IDX_W      (IDX_W)
  ) u_store (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .slot       (slot),
    .entryHiIn  (entryHiIn),
    .entryLo0In (entryLo0In),
    .entryLo1In (entryLo1In),
    .pageMaskIn (pageMaskIn),
    .indexIn    (indexIn),
    .indexOut   (indexOut),
    .entryHiOut (entryHiOut),
    .entryLo0Out(entryLo0Out),
    .entryLo1Out(entryLo1Out),
    .pageMaskOut(pageMaskOut),
    .asidChange (asidChange)
  );

endmodule

// File: tb/tb_soft_tlb.sv
`timescale 1ns/1ps
module tb_soft_tlb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic [1:0]  cmdOp = '0;
  logic [31:0] entryHiIn = '0;
  logic [31:0] entryLo0In = '0;
  logic [31:0] entryLo1In = '0;
  logic [31:0] pageMaskIn = '0;
  logic [31:0] indexIn = '0;
  logic [3:0]  randIdx = '0;
  logic [31:0] indexOut, entryHiOut, entryLo0Out, entryLo1Out, pageMaskOut;
  logic        asidChange;

  int checks = 0;
  int fails  = 0;

  localparam logic [1:0] PROBE = 2'd0, WRIDX = 2'd1, WRRND = 2'd2, READ = 2'd3;

  always #4 clk = ~clk;

  soft_tlb dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .entryHiIn(entryHiIn), .entryLo0In(entryLo0In), .entryLo1In(entryLo1In),
    .pageMaskIn(pageMaskIn), .indexIn(indexIn), .randIdx(randIdx),
    .indexOut(indexOut), .entryHiOut(entryHiOut), .entryLo0Out(entryLo0Out),
    .entryLo1Out(entryLo1Out), .pageMaskOut(pageMaskOut), .asidChange(asidChange)
  );

  function automatic logic [31:0] expHi(input logic [31:0] hi);
    return hi & 32'hFFFF_E0FF;
  endfunction

  function automatic logic [31:0] expLo(input logic [31:0] lo, input logic g);
    return (lo & 32'h3FFF_FFFE) | {31'b0, g};
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  // drives at a falling edge, result is sampled at the next falling edge
  task automatic issue(input logic [1:0] op, input logic [31:0] hi, input logic [31:0] lo0,
                       input logic [31:0] lo1, input logic [31:0] pm,
                       input logic [31:0] idx, input logic [3:0] rnd);
    @(negedge clk);
    cmdOp = op; entryHiIn = hi; entryLo0In = lo0; entryLo1In = lo1;
    pageMaskIn = pm; indexIn = idx; randIdx = rnd; cmdValid = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic applyReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic testReset();
    applyReset();
    chk(indexOut, 32'h0, "R11 index after reset");
    chk(entryHiOut, 32'h0, "R11 hi after reset");
    chk({31'b0, asidChange}, 32'h0, "R11 pulse after reset");
    issue(READ, 32'h0, 32'h0, 32'h0, 32'h0, 32'h5, 4'h0);
    chk(entryLo0Out, 32'h0, "R11 cleared entry lo0");
    chk(pageMaskOut, 32'h0, "R11 cleared entry mask");
    chk(indexOut, 32'h5, "R10 index passes through on read");
  endtask

  task automatic testWriteIndexed();
    issue(WRIDX, 32'hABCD_F7A5, 32'hC123_456F, 32'h4ABC_DEF6, 32'h01FF_E000,
          32'h7FFF_FFF3, 4'hA);
    chk(indexOut, 32'h7FFF_FFF3, "R10 index passes through on write");
    issue(READ, 32'h0000_0011, 32'h0, 32'h0, 32'h0, 32'h3, 4'h0);
    chk(entryHiOut, expHi(32'hABCD_F7A5), "R1 tag and identifier");
    chk(entryLo0Out, expLo(32'hC123_456F, 1'b0), "R2 R3 even half non-global");
    chk(entryLo1Out, expLo(32'h4ABC_DEF6, 1'b0), "R3 odd half");
    chk(pageMaskOut, 32'h01FF_E000, "R4 mask returned");
    chk({31'b0, asidChange}, 32'h1, "R9 pulse on identifier change");
    @(negedge clk);
    chk({31'b0, asidChange}, 32'h0, "R9 pulse lasts one cycle");
  endtask

  task automatic testWriteRandom();
    issue(WRRND, 32'h5555_6033, 32'h0000_00C7, 32'h3000_0041, 32'h0000_6000,
          32'h2, 4'h9);
    issue(READ, 32'h0000_0033, 32'h0, 32'h0, 32'h0, 32'h9, 4'h0);
    chk(entryHiOut, 32'h5555_6033, "R8 random slot written");
    chk(entryLo0Out, 32'h0000_00C7, "R2 global in even half");
    chk(entryLo1Out, 32'h3000_0041, "R2 global in odd half");
    chk({31'b0, asidChange}, 32'h0, "R9 no pulse on same identifier");
    issue(READ, 32'h0, 32'h0, 32'h0, 32'h0, 32'h2, 4'h0);
    chk(entryHiOut, 32'h0, "R8 index slot untouched");
  endtask

  task automatic testUpperIndexIgnored();
    issue(READ, 32'h0000_00A5, 32'h0, 32'h0, 32'h0, 32'hFFFF_FFF3, 4'h0);
    chk(entryHiOut, 32'hABCD_E0A5, "R7 upper index bits ignored");
  endtask

  task automatic testProbe();
    issue(PROBE, 32'hABCD_E0A5, 32'h0, 32'h0, 32'h0, 32'h40, 4'h0);
    chk(indexOut, 32'h3, "R5 probe hit by identifier");
    issue(PROBE, 32'hABCD_E011, 32'h0, 32'h0, 32'h0, 32'h47, 4'h0);
    chk(indexOut, 32'h8000_0047, "R6 probe miss flag");
    issue(PROBE, 32'h5555_60FF, 32'h0, 32'h0, 32'h0, 32'h0, 4'h0);
    chk(indexOut, 32'h9, "R5 probe hit by global");
    issue(WRIDX, 32'h1234_4001, 32'h1, 32'h1, 32'h0, 32'hC, 4'h0);
    issue(WRIDX, 32'h1234_4001, 32'h1, 32'h1, 32'h0, 32'h6, 4'h0);
    issue(PROBE, 32'h1234_4077, 32'h0, 32'h0, 32'h0, 32'h0, 4'h0);
    chk(indexOut, 32'h6, "R5 lowest matching slot");
  endtask

  task automatic testIdleHold();
    logic [31:0] held;
    held = indexOut;
    entryHiIn = 32'hFFFF_FFFF;
    indexIn   = 32'h1;
    repeat (4) @(negedge clk);
    chk(indexOut, held, "R10 index holds while idle");
    chk(entryHiOut, 32'h1234_4077, "R10 hi holds while idle");
  endtask

  task automatic testResetClears();
    applyReset();
    issue(READ, 32'h0, 32'h0, 32'h0, 32'h0, 32'h3, 4'h0);
    chk(entryHiOut, 32'h0, "R11 entry cleared by second reset");
    chk(pageMaskOut, 32'h0, "R11 mask cleared by second reset");
  endtask

  initial begin
    #400000;
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    testReset();
    testWriteIndexed();
    testWriteRandom();
    testUpperIndexIgnored();
    testProbe();
    testIdleHold();
    testResetClears();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule